// File: doc/BRIEF.md
# Card Readout Bus Master and Slaves

This block carries buffered per-channel results from several acquisition cards to a single central collector. Each card holds one slave controller that serves four channel FIFOs. When any of those FIFOs contains a full five-word record, the slave asserts its own request line to the master. A card's results reach the bus one record at a time.

The one master grants the bus to a single card at a time, using round-robin order. Each transfer has a fixed shape: three handshake cycles (grant, acknowledge, turnaround) and then five data cycles. During the acknowledge cycle the slave reports which channel it is sending and whether its card is the priority card. The priority card is the one that carries the absorption-detector data, and the collector routes it separately. After the last data word, the master presents the whole record for one cycle, together with its card number, channel number and priority flag.

The number of cards, the channel count, the word width and the FIFO depth are all parameters.

Top module: `card_readout_bus`

## Requirements
- R1: After reset, `rec_valid` is low, and it stays low as long as no channel has received five words.
- R2: A card requests the bus only while one of its channel FIFOs holds at least five words. A channel holding fewer than five words never produces a record, and every record carries exactly five words.
- R3: A write to a full channel FIFO (FIFO_DEPTH words) is discarded. Accepted words leave each channel in the order they were written, none twice.
- R4: Within a card, the lowest-numbered channel that holds a complete record is sent first.
- R5: When several cards are requesting, the bus goes to the first requesting card after the card granted last, counting upward and wrapping. After reset, the search starts at card 0.
- R6: At most one card holds the grant. The grant stays fixed for one 8-cycle transfer (3 handshake cycles, then 5 data cycles), and the slave acknowledges only in the second cycle of the transfer. Back-to-back records therefore appear on `rec_valid` exactly 9 cycles apart.
- R7: An isolated record appears on `rec_valid` at the 9th rising clock edge after the edge that stores its fifth word.
- R8: `rec_card` and `rec_chan` identify the source of the record. `rec_prio` equals `card_prio[rec_card]`.
- R9: Record word k (k = 0 for the oldest) occupies `rec_data[k*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_wr_en | input | N_CARDS*N_CH | Write strobe, one per channel; index = card*N_CH + channel |
| ch_wr_data | input | N_CARDS*N_CH*DATA_W | Write word for each channel, same index order |
| card_prio | input | N_CARDS | Strap marking the priority card(s) |
| rec_valid | output | 1 | One-cycle strobe for a received record |
| rec_card | output | $clog2(N_CARDS) | Card that sent the record |
| rec_chan | output | $clog2(N_CH) | Channel within that card |
| rec_prio | output | 1 | Priority flag reported by the sending card |
| rec_data | output | 5*DATA_W | The five record words, oldest in the low bits |

## Verification
The wrong internal state is usually a FIFO pointer or count that has drifted, or a latched channel select that is stale. Either one shows up at the ports no later than the next record from that channel: its words arrive out of order, duplicated, or from a different channel than `rec_chan` claims. An arbiter pointer or phase counter that has gone wrong shows up within one transfer time, as a broken 9-cycle spacing or an out-of-order `rec_card` sequence. The bench keeps its own per-channel queues of written words and compares each record against them. It also times records against the write edges.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  // A record is always five words; the handshake in front of it is three cycles.
  localparam int REC_WORDS   = 5;
  localparam int HS_CYCLES   = 3;
  localparam int XFER_CYCLES = HS_CYCLES + REC_WORDS;

  // Transfer phase, broadcast by the master while a card holds the grant.
  typedef enum logic [2:0] {
    PH_GRANT = 3'd0,
    PH_ACK   = 3'd1,
    PH_TURN  = 3'd2,
    PH_D0    = 3'd3,
    PH_D1    = 3'd4,
    PH_D2    = 3'd5,
    PH_D3    = 3'd6,
    PH_D4    = 3'd7
  } phase_t;

  function automatic logic is_data_phase(phase_t p);
    return p >= PH_D0;
  endfunction

  // Slot of the word carried in a data phase (0 = oldest).
  function automatic logic [2:0] data_slot(phase_t p);
    return 3'(p) - 3'(PH_D0);
  endfunction

  function automatic logic is_last_phase(phase_t p);
    return p == PH_D4;
  endfunction

endpackage

// File: rtl/rdb_chan_fifo.sv
module rdb_chan_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              wr_acc;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  // Writes into a full FIFO are dropped, even if a pop happens in the same cycle.
  assign wr_acc = wr_en && (int'(count) < DEPTH);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= ptr_next(wr_ptr);
      if (rd_en)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(wr_acc) - CW'(rd_en);
    end
  end

endmodule

// File: rtl/rdb_slave.sv
module rdb_slave
  import rdb_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CH_W  = $clog2(N_CH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          wr_en,
  input  logic [N_CH*DATA_W-1:0]   wr_data,
  input  logic                     prio_strap,
  input  logic                     gnt,
  input  logic                     busy,
  input  phase_t                   phase,
  output logic                     req,
  output logic                     d_ack,
  output logic                     d_prio,
  output logic [CH_W-1:0]          d_chan,
  output logic [DATA_W-1:0]        d_data
);

  logic [CW-1:0]     cnt  [N_CH];
  logic [DATA_W-1:0] head [N_CH];
  logic [N_CH-1:0]   ready, pop;
  logic [CH_W-1:0]   sel;
  logic              mine, sending;

  // Lowest-numbered channel holding a full record.
  function automatic logic [CH_W-1:0] first_ready(logic [N_CH-1:0] r);
    logic [CH_W-1:0] pick;
    pick = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (r[c]) pick = CH_W'(c);
    end
    return pick;
  endfunction

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    rdb_chan_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[c]),
      .wr_data (wr_data[c*DATA_W +: DATA_W]),
      .rd_en   (pop[c]),
      .head    (head[c]),
      .count   (cnt[c])
    );
    assign ready[c] = int'(cnt[c]) >= REC_WORDS;
    assign pop[c]   = sending && (sel == CH_W'(c));
  end

  assign req     = |ready;
  assign mine    = gnt && busy;
  assign sending = mine && is_data_phase(phase);

  // The channel is chosen in the grant cycle and held for the whole transfer.
  always_ff @(posedge clk) begin
    if (!rst_n) sel <= '0;
    else if (mine && phase == PH_GRANT) sel <= first_ready(ready);
  end

  // Every output is zero unless this card owns the bus, so the top can OR them.
  assign d_ack  = mine && (phase == PH_ACK);
  assign d_prio = d_ack && prio_strap;
  assign d_chan = d_ack ? sel : '0;
  assign d_data = sending ? head[sel] : '0;

endmodule

// File: rtl/rdb_master.sv
module rdb_master
  import rdb_pkg::*;
#(
  parameter int N_CARDS = 4,
  parameter int N_CH    = 4,
  parameter int DATA_W  = 16,
  localparam int CARD_W = $clog2(N_CARDS),
  localparam int CH_W   = $clog2(N_CH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CARDS-1:0]          req,
  input  logic                        bus_ack,
  input  logic                        bus_prio,
  input  logic [CH_W-1:0]             bus_chan,
  input  logic [DATA_W-1:0]           bus_data,
  output logic [N_CARDS-1:0]          gnt,
  output logic                        busy,
  output phase_t                      phase,
  output logic                        rec_valid,
  output logic [CARD_W-1:0]           rec_card,
  output logic [CH_W-1:0]             rec_chan,
  output logic                        rec_prio,
  output logic [REC_WORDS*DATA_W-1:0] rec_data
);

  logic [CARD_W-1:0] cur, last;
  logic [CH_W-1:0]   lat_chan;
  logic              lat_prio;
  logic [DATA_W-1:0] words [REC_WORDS-1];

  // Round-robin: first requester strictly after the last granted card.
  function automatic logic [CARD_W-1:0] rr_pick(logic [N_CARDS-1:0] r,
                                                logic [CARD_W-1:0] prev);
    logic [CARD_W-1:0] pick;
    logic              found;
    int                k;
    pick  = prev;
    found = 1'b0;
    for (int off = 1; off <= N_CARDS; off++) begin
      k = (int'(prev) + off) % N_CARDS;
      if (!found && r[k]) begin
        pick  = CARD_W'(k);
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  always_comb begin
    gnt = '0;
    if (busy) gnt[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      phase     <= PH_GRANT;
      cur       <= '0;
      last      <= CARD_W'(N_CARDS - 1);
      lat_chan  <= '0;
      lat_prio  <= 1'b0;
      rec_valid <= 1'b0;
      rec_card  <= '0;
      rec_chan  <= '0;
      rec_prio  <= 1'b0;
      rec_data  <= '0;
    end else begin
      rec_valid <= 1'b0;
      if (!busy) begin
        if (|req) begin
          cur   <= rr_pick(req, last);
          last  <= rr_pick(req, last);
          busy  <= 1'b1;
          phase <= PH_GRANT;
        end
      end else begin
        phase <= phase_t'(phase + 3'd1);
        if (phase == PH_ACK && bus_ack) begin
          lat_chan <= bus_chan;
          lat_prio <= bus_prio;
        end
        if (is_last_phase(phase)) begin
          busy      <= 1'b0;
          rec_valid <= 1'b1;
          rec_card  <= cur;
          rec_chan  <= lat_chan;
          rec_prio  <= lat_prio;
          rec_data  <= {bus_data, words[3], words[2], words[1], words[0]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && is_data_phase(phase) && !is_last_phase(phase))
      words[data_slot(phase)] <= bus_data;
  end

endmodule

// File: rtl/card_readout_bus.sv
module card_readout_bus
  import rdb_pkg::*;
#(
  parameter int N_CARDS    = 4,
  parameter int N_CH       = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int CARD_W    = $clog2(N_CARDS),
  localparam int CH_W      = $clog2(N_CH),
  localparam int N_LANES   = N_CARDS * N_CH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LANES-1:0]          ch_wr_en,
  input  logic [N_LANES*DATA_W-1:0]   ch_wr_data,
  input  logic [N_CARDS-1:0]          card_prio,
  output logic                        rec_valid,
  output logic [CARD_W-1:0]           rec_card,
  output logic [CH_W-1:0]             rec_chan,
  output logic                        rec_prio,
  output logic [REC_WORDS*DATA_W-1:0] rec_data
);

  // Shared bus: named so the checker can watch it.
  logic [N_CARDS-1:0] card_req;
  logic [N_CARDS-1:0] bus_gnt;
  logic               bus_busy;
  phase_t             bus_phase;
  logic               bus_ack, bus_prio;
  logic [CH_W-1:0]    bus_chan;
  logic [DATA_W-1:0]  bus_data;

  logic [N_CARDS-1:0] s_ack, s_prio;
  logic [CH_W-1:0]    s_chan [N_CARDS];
  logic [DATA_W-1:0]  s_data [N_CARDS];

  for (genvar k = 0; k < N_CARDS; k++) begin : g_card
    rdb_slave #(.N_CH(N_CH), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (ch_wr_en[k*N_CH +: N_CH]),
      .wr_data    (ch_wr_data[k*N_CH*DATA_W +: N_CH*DATA_W]),
      .prio_strap (card_prio[k]),
      .gnt        (bus_gnt[k]),
      .busy       (bus_busy),
      .phase      (bus_phase),
      .req        (card_req[k]),
      .d_ack      (s_ack[k]),
      .d_prio     (s_prio[k]),
      .d_chan     (s_chan[k]),
      .d_data     (s_data[k])
    );
  end

  // Only the granted slave drives non-zero values, so OR-combining forms the bus.
  always_comb begin
    bus_ack  = |s_ack;
    bus_prio = |s_prio;
    bus_chan = '0;
    bus_data = '0;
    for (int k = 0; k < N_CARDS; k++) begin
      bus_chan = bus_chan | s_chan[k];
      bus_data = bus_data | s_data[k];
    end
  end

  rdb_master #(.N_CARDS(N_CARDS), .N_CH(N_CH), .DATA_W(DATA_W)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (card_req),
    .bus_ack   (bus_ack),
    .bus_prio  (bus_prio),
    .bus_chan  (bus_chan),
    .bus_data  (bus_data),
    .gnt       (bus_gnt),
    .busy      (bus_busy),
    .phase     (bus_phase),
    .rec_valid (rec_valid),
    .rec_card  (rec_card),
    .rec_chan  (rec_chan),
    .rec_prio  (rec_prio),
    .rec_data  (rec_data)
  );

endmodule

// File: rtl/rdb_checker.sv
module rdb_checker #(
  parameter int N_CARDS = 4,
  localparam int CARD_W = $clog2(N_CARDS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CARDS-1:0] card_req,
  input logic [N_CARDS-1:0] bus_gnt,
  input logic               bus_busy,
  input logic [2:0]         bus_phase,
  input logic               bus_ack,
  input logic               rec_valid,
  input logic [CARD_W-1:0]  rec_card,
  input logic               rec_prio,
  input logic [N_CARDS-1:0] card_prio
);

  p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt));

  p_grant_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && bus_phase != 3'd7) |=> (bus_busy && $stable(bus_gnt)));

  p_phase_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && bus_phase != 3'd7) |=> (bus_phase == $past(bus_phase) + 3'd1));

  p_ack_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (bus_busy && bus_phase == 3'd1));

  p_ack_given_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && bus_phase == 3'd1) |-> bus_ack);

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && bus_phase == 3'd0) |-> (($past(card_req) & bus_gnt) != '0));

  p_rec_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(bus_busy && bus_phase == 3'd7));

  p_prio_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_prio == card_prio[rec_card]));

endmodule

bind card_readout_bus rdb_checker #(.N_CARDS(N_CARDS)) u_rdb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_req  (card_req),
  .bus_gnt   (bus_gnt),
  .bus_busy  (bus_busy),
  .bus_phase (bus_phase),
  .bus_ack   (bus_ack),
  .rec_valid (rec_valid),
  .rec_card  (rec_card),
  .rec_prio  (rec_prio),
  .card_prio (card_prio)
);

// File: tb/tb_card_readout_bus.sv
module tb_card_readout_bus;

  localparam int NC = 4;
  localparam int NH = 4;
  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int NL = NC * NH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    ch_wr_en = '0;
  logic [NL*DW-1:0] ch_wr_data = '0;
  logic [NC-1:0]    card_prio = 4'b0100;
  logic             rec_valid;
  logic [1:0]       rec_card, rec_chan;
  logic             rec_prio;
  logic [5*DW-1:0]  rec_data;

  card_readout_bus #(.N_CARDS(NC), .N_CH(NH), .DATA_W(DW), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ch_wr_en(ch_wr_en), .ch_wr_data(ch_wr_data),
    .card_prio(card_prio), .rec_valid(rec_valid), .rec_card(rec_card),
    .rec_chan(rec_chan), .rec_prio(rec_prio), .rec_data(rec_data));

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0, ovf_mode = 0;
  int seq [NL];
  logic [DW-1:0] wr_q [NL][$];
  logic [DW-1:0] rx_q [NL][$];
  int n_rec, last_wr_cyc;
  int log_card [64], log_chan [64], log_prio [64], log_cyc [64];
  logic [DW-1:0] log_w0 [64], log_w4 [64];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] exp_word(int lane, int s);
    return {4'(lane), 12'(s)};
  endfunction

  // Bench restatement of round-robin: next requester after prev, wrapping.
  function automatic int rr_next(int prev, logic [NC-1:0] mask);
    for (int i = 1; i <= NC; i++)
      if (mask[(prev + i) % NC]) return (prev + i) % NC;
    return prev;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: log each record; in exact mode compare with the written stream.
  always @(negedge clk) begin
    if (rst_n && rec_valid) begin
      int lane;
      int bad;
      lane = int'(rec_card) * NH + int'(rec_chan);
      if (n_rec < 64) begin
        log_card[n_rec] = int'(rec_card);
        log_chan[n_rec] = int'(rec_chan);
        log_prio[n_rec] = int'(rec_prio);
        log_cyc[n_rec]  = cyc;
        log_w0[n_rec]   = rec_data[0 +: DW];
        log_w4[n_rec]   = rec_data[4*DW +: DW];
      end
      n_rec++;
      chk(rec_prio == card_prio[rec_card], "R8", "priority flag", int'(rec_prio),
          int'(card_prio[rec_card]));
      if (ovf_mode) begin
        for (int w = 0; w < 5; w++) rx_q[lane].push_back(rec_data[w*DW +: DW]);
      end else begin
        bad = -1;
        for (int w = 0; w < 5; w++) begin
          if (wr_q[lane].size() == 0) bad = 0;
          else if (wr_q[lane].pop_front() != rec_data[w*DW +: DW] && bad < 0)
            bad = int'(rec_data[w*DW +: DW]);
        end
        chk(bad < 0, "R9", "record words in written order", bad, -1);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    ch_wr_en = '0;
    repeat (3) @(negedge clk);
    n_rec = 0;
    for (int i = 0; i < NL; i++) begin
      seq[i] = 0;
      wr_q[i].delete();
      rx_q[i].delete();
    end
    rst_n = 1'b1;
  endtask

  // Write nwords consecutive words to every lane in mask (called at a negedge).
  task automatic load(logic [NL-1:0] mask, int nwords);
    for (int n = 0; n < nwords; n++) begin
      for (int i = 0; i < NL; i++) if (mask[i]) begin
        ch_wr_data[i*DW +: DW] = exp_word(i, seq[i]);
        wr_q[i].push_back(exp_word(i, seq[i]));
        seq[i]++;
      end
      ch_wr_en = mask;
      last_wr_cyc = cyc;
      @(negedge clk);
      ch_wr_en = '0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd2718);
    @(negedge clk);

    // Reset state
    do_reset();
    chk(rec_valid == 1'b0, "R1", "rec_valid after reset", int'(rec_valid), 0);
    idle(20);
    chk(n_rec == 0, "R1", "no record while idle", n_rec, 0);

    // Partial record, then completion and latency
    load(16'h0001, 4);
    idle(40);
    chk(n_rec == 0, "R2", "four words give no record", n_rec, 0);
    load(16'h0001, 1);
    idle(15);
    chk(n_rec == 1, "R2", "fifth word gives one record", n_rec, 1);
    chk(log_cyc[0] == last_wr_cyc + 10, "R7", "record latency", log_cyc[0], last_wr_cyc + 10);
    chk(log_card[0] == 0 && log_chan[0] == 0, "R8", "source card*4+chan",
        log_card[0] * 4 + log_chan[0], 0);
    chk(log_w0[0] == exp_word(0, 0), "R9", "word 0 in low bits", int'(log_w0[0]), int'(exp_word(0, 0)));
    chk(log_w4[0] == exp_word(0, 4), "R9", "word 4 in high bits", int'(log_w4[0]), int'(exp_word(0, 4)));

    // Channel order within one card: channels 3 and 1 of card 1 fill together
    do_reset();
    load(16'h00A0, 5);
    idle(40);
    chk(n_rec == 2, "R4", "two records", n_rec, 2);
    chk(log_chan[0] == 1, "R4", "lower channel first", log_chan[0], 1);
    chk(log_chan[1] == 3, "R4", "higher channel second", log_chan[1], 3);
    chk(log_card[0] == 1 && log_card[1] == 1, "R8", "card of both", log_card[1], 1);
    chk(log_cyc[1] - log_cyc[0] == 9, "R6", "back-to-back spacing", log_cyc[1] - log_cyc[0], 9);

    // Round-robin over all cards, channel 2 of each
    do_reset();
    load(16'h4444, 5);
    idle(60);
    chk(n_rec == 4, "R5", "four records", n_rec, 4);
    begin
      int prev;
      prev = NC - 1;
      for (int r = 0; r < 4; r++) begin
        prev = rr_next(prev, 4'b1111);
        chk(log_card[r] == prev, "R5", "grant order", log_card[r], prev);
        chk(log_prio[r] == int'(card_prio[prev]), "R8", "priority per card", log_prio[r],
            int'(card_prio[prev]));
        if (r > 0) chk(log_cyc[r] - log_cyc[r-1] == 9, "R6", "spacing", log_cyc[r] - log_cyc[r-1], 9);
      end
      load(16'h1010, 5);
      idle(40);
      prev = rr_next(3, 4'b1010);
      chk(log_card[4] == prev, "R5", "wrap after last card", log_card[4], prev);
      prev = rr_next(prev, 4'b1000);
      chk(log_card[5] == prev, "R5", "then remaining card", log_card[5], prev);
    end

    // Overflow: 60 back-to-back writes to card 1 channel 0 (lane 4)
    do_reset();
    ovf_mode = 1;
    load(16'h0010, 60);
    idle(200);
    begin
      int rx_n, j;
      bit subseq, head_ok;
      rx_n = rx_q[4].size();
      chk(rx_n < 60, "R3", "some writes dropped", rx_n, 59);
      chk(rx_n % 5 == 0 && rx_n > 0, "R2", "whole records only", rx_n % 5, 0);
      head_ok = rx_n >= DEPTH;
      for (int i = 0; i < DEPTH && i < rx_n; i++)
        if (rx_q[4][i] != exp_word(4, i)) head_ok = 0;
      chk(head_ok, "R3", "first DEPTH words kept", rx_n, DEPTH);
      subseq = 1;
      j = 0;
      for (int i = 0; i < rx_n; i++) begin
        while (j < 60 && exp_word(4, j) != rx_q[4][i]) j++;
        if (j >= 60) subseq = 0;
        j++;
      end
      chk(subseq, "R3", "accepted words in order, none twice", int'(subseq), 1);
    end
    ovf_mode = 0;

    // Constrained random traffic with a different priority strap
    card_prio = 4'b0001;
    do_reset();
    begin
      int expect_rec;
      logic [NL-1:0] m;
      for (int c = 0; c < 3000; c++) begin
        m = '0;
        for (int i = 0; i < NL; i++) m[i] = ($urandom % 64) == 0;
        if (m != '0) load(m, 1);
        else idle(1);
      end
      idle(400);
      expect_rec = 0;
      for (int i = 0; i < NL; i++) expect_rec += seq[i] / 5;
      chk(n_rec == expect_rec, "R2", "record count from random writes", n_rec, expect_rec);
      for (int i = 0; i < NL; i++)
        chk(wr_q[i].size() < 5, "R2", "residue below one record", wr_q[i].size(), 4);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule